// File: doc/BRIEF.md
# UART Register File with Prioritised Interrupt Identification

This block is the register side of a 16550-style serial port. A 32-bit, word-addressed register bus reads and writes eight registers. On the line side the block receives one byte at a time from a deserialiser and hands one byte at a time to a serialiser. The block keeps the enable, line-control, modem-control and divisor settings and exports them to the bit-level logic. It holds a single received byte, keeps the line and modem status flags, and drives one interrupt line. A 3-bit identification code names the most urgent pending cause. The serialiser, the deserialiser, the baud generator and any FIFO are outside the block.

A bus access is one cycle with `bus_sel` high. `bus_wr` chooses write or read. The byte address is the word index times four, and its two low bits must be zero. Read data and the illegal-access flag are registered and appear in the cycle after the access. Every side effect of an access (clearing data-ready, clearing error flags, starting a transmit) takes effect at the edge of the access. Because `irq` and `irq_id` are combinational from the stored state, they show the new state in the same cycle that read data returns.

Top module: `uart_regblock`

## Requirements
- R1: After synchronous active-low reset, line status reads 0x60 (bits 5 and 6 set), identification reads 3'b001, modem status reads zero, `irq` is low, `tx_valid` is low, `rx_ready` is high, and the exported line-control, modem-control and divisor values are zero.
- R2: Word indices 1 (enable, bits 3:0 are receive-data, transmit-empty, line-error and modem enables from bit 0 up), 3 (line control), 4 (modem control) and 7 (divisor) take the write data and export it. Reading any of them returns zero.
- R3: Writes to word indices 2 (identification), 5 (line status) and 6 (modem status) have no effect on any of them.
- R4: A byte offered with `rx_valid` is stored and sets data-ready (line-status bit 0). `rx_ready` is low while data-ready is set. Reading word index 0 returns the stored byte in bits 7:0 and clears data-ready.
- R5: A byte that arrives while data-ready is set replaces the stored byte, keeps data-ready set and sets overrun (line-status bit 1).
- R6: The `rx_perr`, `rx_ferr` and `rx_brk` sidebands of an arriving byte set line-status bits 2, 3 and 4. Reading line status returns the flags and then clears bits 1 to 4, leaving data-ready unchanged.
- R7: A write to word index 0 drives bits 7:0 onto `tx_byte` with `tx_valid` high and clears line-status bits 5 and 6. `tx_byte` stays stable until `tx_ready` is seen. Both bits are set again in the cycle after acceptance.
- R8: The identification code follows a fixed priority. 3'b110 means any of line-status bits 1 to 4 is set with the line-error enable on. Otherwise 3'b100 means data-ready with the receive enable on. Otherwise 3'b010 means transmit-empty with the transmit enable on. Otherwise 3'b000 means any of modem-status bits 3:0 with the modem enable on. Otherwise the code is 3'b001. Reading word index 2 returns the code in bits 2:0.
- R9: `irq` is high exactly when the identification code differs from 3'b001.
- R10: An access with a word index above 7 or a nonzero low address pair reads zero, changes no state, and raises `bus_bad` for exactly the one cycle after it.
- R11: Modem status (word index 6) is a registered copy of `modem_in`, taken every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| bus_bad | output | 1 | Illegal-access pulse, the cycle after the access |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_ready | output | 1 | Holding register empty (advisory) |
| rx_byte | input | BYTE_W | Received byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break seen with this byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Serialiser takes the pending byte |
| tx_byte | output | BYTE_W | Byte to transmit |
| modem_in | input | 8 | Modem status flags from the line side |
| irq | output | 1 | Interrupt request |
| irq_id | output | 3 | Identification code of the top pending cause |
| lctl_out | output | 8 | Stored line-control value |
| mctl_out | output | 8 | Stored modem-control value |
| div_out | output | DIV_W | Stored divisor value |

## Verification
The bench builds the block with the default 8-bit address and byte width and with a 16-bit divisor. The narrow divisor lets the test show that the high write bits are dropped. With the 8-bit address, all 56 out-of-range word indices can be reached, and each one is read and shown to have no effect. The interrupt priority is swept over all 16 enable patterns crossed with every combination of line error, data-ready, transmit-empty and modem delta, which gives 256 cases. Each case is checked at the `irq` and `irq_id` pins and through a bus read of the identification register.

// File: rtl/uart_rb_pkg.sv
// Shared register indices, identification codes and flag types for the
// UART register file. Assumes a 32-bit word-addressed bus of eight words.
package uart_rb_pkg;

    localparam int REG_COUNT = 8;

    typedef enum logic [2:0] {
        IDX_DATA  = 3'd0,
        IDX_IEN   = 3'd1,
        IDX_IID   = 3'd2,
        IDX_LCTL  = 3'd3,
        IDX_MCTL  = 3'd4,
        IDX_LSTAT = 3'd5,
        IDX_MSTAT = 3'd6,
        IDX_DIV   = 3'd7
    } reg_idx_e;

    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_THR   = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;
    localparam logic [2:0] IID_NONE  = 3'b001;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
        logic ovr;
        logic dr;
    } rx_flags_t;

endpackage

// File: rtl/uart_rb_decode.sv
// Address decoder: splits a byte address into a register index and flags
// accesses that are misaligned or beyond the last register.
// Assumes NUM_REGS is a power of two no larger than the word space.
module uart_rb_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic                        sel,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    output logic                        acc_rd,
    output logic                        acc_wr,
    output logic [$clog2(NUM_REGS)-1:0] reg_sel,
    output logic                        illegal
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] word;
    logic             legal;

    // Classify the address and produce qualified read/write strobes
    always_comb begin
        word    = addr[ADDR_W-1:2];
        legal   = (addr[1:0] == 2'b00) && (word < IDX_W'(NUM_REGS));
        reg_sel = word[SEL_W-1:0];
        acc_rd  = sel && !wr && legal;
        acc_wr  = sel &&  wr && legal;
        illegal = sel && !legal;
    end
endmodule

// File: rtl/uart_rb_rx.sv
// Receive holding register: one byte plus data-ready, overrun and the
// per-byte error flags. Bytes are taken on any cycle rx_valid is high;
// rx_ready is only a hint to the source. An arrival beats a same-cycle read.
module uart_rb_rx
    import uart_rb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rd_data,
    input  logic              rd_stat,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] hold,
    output rx_flags_t         flags
);
    logic overrun_now;

    // An arrival is an overrun when the held byte was neither read nor drained
    always_comb overrun_now = rx_valid && flags.dr && !rd_data;

    // Hold the byte and update the flags on arrival, data read and status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            flags <= '0;
        end else begin
            if (rx_valid) begin
                hold     <= rx_byte;
                flags.dr <= 1'b1;
            end else if (rd_data) begin
                flags.dr <= 1'b0;
            end
            flags.ovr  <= (rd_stat ? 1'b0 : flags.ovr)  | overrun_now;
            flags.perr <= (rd_stat ? 1'b0 : flags.perr) | (rx_valid && rx_perr);
            flags.ferr <= (rd_stat ? 1'b0 : flags.ferr) | (rx_valid && rx_ferr);
            flags.brk  <= (rd_stat ? 1'b0 : flags.brk)  | (rx_valid && rx_brk);
        end
    end

    // Advertise room only while nothing is held
    always_comb rx_ready = !flags.dr;

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (flags.dr && hold == $past(rx_byte)));
    // R4
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !flags.dr);
    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && flags.dr && !rd_data) |=> flags.ovr);
endmodule

// File: rtl/uart_rb_tx.sv
// Transmit holding stage: a data-register write loads the byte and raises
// tx_valid until the serialiser accepts it. A write while a byte is pending
// replaces it. Assumes tx_ready may be high at any time.
module uart_rb_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_empty
);
    // Load on write, release on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else if (wr_data) begin
            tx_valid <= 1'b1;
            tx_byte  <= wdata;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // Holding stage empty whenever no byte is pending
    always_comb tx_empty = !tx_valid;

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_data) |=> (tx_valid && $stable(tx_byte)));
    // R7
    tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wr_data) |=> tx_empty);
endmodule

// File: rtl/uart_rb_irq.sv
// Interrupt resolver: combines enabled causes into one request line and
// a priority-ordered identification code. Purely combinational.
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       line_err,
    input  logic       data_rdy,
    input  logic       thr_empty,
    input  logic [3:0] modem_delta,
    output logic       irq,
    output logic [2:0] irq_id
);
    logic [3:0] cause;

    // Gate each cause with its enable: bit3 line, bit2 rx, bit1 tx, bit0 modem
    always_comb begin
        cause[3] = line_err  && ien[2];
        cause[2] = data_rdy  && ien[0];
        cause[1] = thr_empty && ien[1];
        cause[0] = (|modem_delta) && ien[3];
        irq      = |cause;
    end

    // Pick the highest-priority cause
    always_comb begin
        if (cause[3])      irq_id = IID_LINE;
        else if (cause[2]) irq_id = IID_RXD;
        else if (cause[1]) irq_id = IID_THR;
        else if (cause[0]) irq_id = IID_MODEM;
        else               irq_id = IID_NONE;
    end
endmodule

// File: rtl/uart_regblock.sv
// UART register file top: bus decode, control registers, status assembly,
// registered read data and interrupt resolution. Read data and the illegal
// flag lag the access by one cycle; all side effects land at the access edge.
// Assumes DIV_W <= DATA_W and BYTE_W == 8.
module uart_regblock
    import uart_rb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_bad,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic [7:0]        modem_in,
    output logic              irq,
    output logic [2:0]        irq_id,
    output logic [7:0]        lctl_out,
    output logic [7:0]        mctl_out,
    output logic [DIV_W-1:0]  div_out
);
    localparam int SEL_W  = $clog2(REG_COUNT);
    localparam int LSR_W  = 7;

    logic              acc_rd, acc_wr, illegal;
    logic [SEL_W-1:0]  reg_sel;
    logic              rd_data, rd_stat, wr_data;
    logic [3:0]        ien_q;
    logic [7:0]        lctl_q, mctl_q, msr_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rd_next, rd_q;
    logic              bad_q;
    logic [BYTE_W-1:0] rx_hold;
    rx_flags_t         rx_flags;
    logic              tx_empty;
    logic [LSR_W-1:0]  lsr;

    uart_rb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(REG_COUNT)) i_decode (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .reg_sel(reg_sel), .illegal(illegal)
    );

    // Side-effecting strobes for the data and line-status registers
    always_comb begin
        rd_data = acc_rd && (reg_sel == IDX_DATA);
        rd_stat = acc_rd && (reg_sel == IDX_LSTAT);
        wr_data = acc_wr && (reg_sel == IDX_DATA);
    end

    uart_rb_rx #(.BYTE_W(BYTE_W)) i_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .rd_data(rd_data), .rd_stat(rd_stat),
        .rx_ready(rx_ready), .hold(rx_hold), .flags(rx_flags)
    );

    uart_rb_tx #(.BYTE_W(BYTE_W)) i_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_data), .wdata(bus_wdata[BYTE_W-1:0]),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_empty(tx_empty)
    );

    // Assemble line status: empty flags on top, receive flags below
    always_comb lsr = {tx_empty, tx_empty, rx_flags.brk, rx_flags.ferr,
                       rx_flags.perr, rx_flags.ovr, rx_flags.dr};

    uart_rb_irq i_irq (
        .ien(ien_q),
        .line_err(rx_flags.ovr | rx_flags.perr | rx_flags.ferr | rx_flags.brk),
        .data_rdy(rx_flags.dr), .thr_empty(tx_empty),
        .modem_delta(msr_q[3:0]),
        .irq(irq), .irq_id(irq_id)
    );

    // Write-only control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            div_q  <= '0;
        end else if (acc_wr) begin
            case (reg_idx_e'(reg_sel))
                IDX_IEN:  ien_q  <= bus_wdata[3:0];
                IDX_LCTL: lctl_q <= bus_wdata[7:0];
                IDX_MCTL: mctl_q <= bus_wdata[7:0];
                IDX_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sample modem status from the line side every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= modem_in;
    end

    // Select read data for readable registers; everything else reads zero
    always_comb begin
        rd_next = '0;
        if (acc_rd) begin
            case (reg_idx_e'(reg_sel))
                IDX_DATA:  rd_next[BYTE_W-1:0] = rx_hold;
                IDX_IID:   rd_next[2:0]        = irq_id;
                IDX_LSTAT: rd_next[LSR_W-1:0]  = lsr;
                IDX_MSTAT: rd_next[7:0]        = msr_q;
                default:   ;
            endcase
        end
    end

    // Register read data and the illegal-access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            bad_q <= 1'b0;
        end else begin
            rd_q  <= rd_next;
            bad_q <= illegal;
        end
    end

    // Drive the outputs from the stored state
    always_comb begin
        bus_rdata = rd_q;
        bus_bad   = bad_q;
        lctl_out  = lctl_q;
        mctl_out  = mctl_q;
        div_out   = div_q;
    end

    // R9
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_id != IID_NONE));
    // R10
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_bad);
    // R10
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr[1:0] != 2'b00) |=> (bus_bad && bus_rdata == '0));
    // R11
    modem_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (msr_q == $past(modem_in)));
endmodule

// File: tb/test_uart_regblock.sv
`timescale 1ns/1ps
module test_uart_regblock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_bad;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_byte = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic        tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_byte;
    logic [7:0]  modem_in = '0;
    logic        irq;
    logic [2:0]  irq_id;
    logic [7:0]  lctl_out, mctl_out;
    logic [15:0] div_out;

    int n_chk = 0, n_err = 0;
    logic [31:0] rd;
    logic        bad;

    uart_regblock #(.DIV_W(16)) i_uart_regblock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_bad(bus_bad), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .modem_in(modem_in), .irq(irq), .irq_id(irq_id),
        .lctl_out(lctl_out), .mctl_out(mctl_out), .div_out(div_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; bad = bus_bad;
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        bus(1'b1, 8'(idx * 4), d);
    endtask

    task automatic rreg(input int idx);
        bus(1'b0, 8'(idx * 4), 32'h0);
    endtask

    task automatic push(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    function automatic logic [2:0] exp_id(input int ier, input bit e, input bit d,
                                          input bit t, input bit m);
        if (e && ier[2])      return 3'b110;
        else if (d && ier[0]) return 3'b100;
        else if (t && ier[1]) return 3'b010;
        else if (m && ier[3]) return 3'b000;
        else                  return 3'b001;
    endfunction

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 irq_id", 32'(irq_id), 1);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 lctl", 32'(lctl_out), 0);
        chk("R1 mctl", 32'(mctl_out), 0);
        chk("R1 div", 32'(div_out), 0);
        rreg(5); chk("R1 line status", rd, 32'h60);
        rreg(2); chk("R1 ident", rd, 32'h1);
        rreg(6); chk("R1 modem status", rd, 32'h0);

        // R2 write-only registers
        wreg(3, 32'h3B); chk("R2 lctl", 32'(lctl_out), 32'h3B);
        rreg(3); chk("R2 lctl read", rd, 0);
        wreg(4, 32'h03); chk("R2 mctl", 32'(mctl_out), 32'h03);
        rreg(4); chk("R2 mctl read", rd, 0);
        wreg(7, 32'h12345); chk("R2 div", 32'(div_out), 32'h2345);
        rreg(7); chk("R2 div read", rd, 0);
        wreg(1, 32'h2); chk("R2 ien tx enable", 32'(irq_id), 32'h2);
        rreg(1); chk("R2 ien read", rd, 0);
        wreg(1, 32'h0);

        // R3 read-only registers
        wreg(5, 32'hFF); rreg(5); chk("R3 line status", rd, 32'h60);
        wreg(2, 32'hFF); rreg(2); chk("R3 ident", rd, 32'h1);
        wreg(6, 32'hFF); rreg(6); chk("R3 modem status", rd, 32'h0);

        // R11 modem copy
        @(negedge clk); modem_in = 8'hA5;
        @(negedge clk);
        rreg(6); chk("R11 modem status", rd, 32'hA5);
        modem_in = 8'h00; @(negedge clk);

        // R4 receive and drain
        push(8'h3C, 0, 0, 0);
        chk("R4 rx_ready low", 32'(rx_ready), 0);
        rreg(5); chk("R4 data ready", rd, 32'h61);
        rreg(0); chk("R4 data", rd, 32'h3C);
        chk("R4 rx_ready high", 32'(rx_ready), 1);
        rreg(5); chk("R4 drained", rd, 32'h60);

        // R5 overrun
        push(8'h11, 0, 0, 0);
        push(8'h22, 0, 0, 0);
        rreg(5); chk("R5 overrun flags", rd, 32'h63);
        rreg(0); chk("R5 newest byte", rd, 32'h22);
        rreg(5); chk("R5 cleared by status read", rd, 32'h60);

        // R6 error sidebands and clear-on-read
        push(8'h55, 1, 0, 0);
        rreg(5); chk("R6 parity", rd, 32'h65);
        rreg(5); chk("R6 parity cleared", rd, 32'h61);
        push(8'h66, 0, 1, 1);
        rreg(0); chk("R6 data", rd, 32'h66);
        rreg(5); chk("R6 frame+break+overrun", rd, 32'h7A);
        rreg(5); chk("R6 all cleared", rd, 32'h60);

        // R7 transmit handshake
        tx_ready = 1'b0;
        wreg(0, 32'h1A5);
        chk("R7 tx_valid", 32'(tx_valid), 1);
        chk("R7 tx_byte", 32'(tx_byte), 32'hA5);
        rreg(5); chk("R7 empty flags low", rd, 32'h00);
        chk("R7 byte stable", 32'(tx_byte), 32'hA5);
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R7 accepted", 32'(tx_valid), 0);
        rreg(5); chk("R7 empty flags back", rd, 32'h60);

        // R8 / R9 priority sweep
        for (int c = 0; c < 256; c++) begin
            int ier;
            bit e, d, t, m;
            ier = c & 15; e = c[4]; d = c[5]; t = c[6]; m = c[7];
            tx_ready = 1'b1; modem_in = 8'h00;
            wreg(1, 0); rreg(0); rreg(5);
            if (e) push(8'h5A, 1, 0, 0);
            if (e && !d) rreg(0);
            if (!e && d) push(8'hA5, 0, 0, 0);
            if (!t) begin tx_ready = 1'b0; wreg(0, 32'h77); end
            modem_in = m ? 8'h01 : 8'h00;
            @(negedge clk);
            wreg(1, 32'(ier));
            chk("R8 irq_id", 32'(irq_id), 32'(exp_id(ier, e, d, t, m)));
            chk("R9 irq", 32'(irq), 32'(exp_id(ier, e, d, t, m) != 3'b001));
            rreg(2);
            chk("R8 ident read", rd, 32'(exp_id(ier, e, d, t, m)));
        end
        tx_ready = 1'b1; modem_in = 8'h00;
        wreg(1, 0); rreg(0); rreg(5);

        // R10 illegal accesses
        for (int i = 8; i < 64; i++) begin
            rreg(i);
            chk("R10 out-of-range data", rd, 0);
            chk("R10 out-of-range flag", 32'(bad), 1);
            @(negedge clk);
            chk("R10 single pulse", 32'(bus_bad), 0);
        end
        bus(1'b1, 8'h0D, 32'hFF);
        chk("R10 misaligned flag", 32'(bad), 1);
        chk("R10 lctl untouched", 32'(lctl_out), 32'h3B);
        bus(1'b1, 8'h21, 32'hFF);
        chk("R10 tx untouched", 32'(tx_valid), 0);
        push(8'h99, 0, 0, 0);
        bus(1'b0, 8'h01, 32'h0);
        chk("R10 misaligned read", rd, 0);
        rreg(5); chk("R10 data ready kept", rd, 32'h61);
        rreg(0); chk("R10 byte kept", rd, 32'h99);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule